// File: doc/BRIEF.md
# Multi-Mode Host Bus Front End

This block is the host-facing entry point of a display controller. A microprocessor writes command and display bytes through it and reads bytes back. Three static configuration inputs select the bus style: a 6800-style parallel bus with a read/write level and an enable strobe, an 8080-style parallel bus with separate active-low write and read strobes, a 4-bit variant of either parallel style in which each byte crosses the top half of the bus in two steps, or a two-wire serial link. Every finished byte leaves the block as a one-cycle `out_valid` pulse with an `out_is_data` tag. The tag is taken from the data/command select input. Read data supplied by the controller is returned on the bus output, and the output enable marks when the pad may be driven.

All host pins cross into the internal clock through two-stage synchronisers. Edge detectors then turn strobe releases and serial clock rises into single-cycle events. The parallel receiver has two small state machines. The write-phase machine has states WR_EXPECT_HI and WR_EXPECT_LO. It moves HI to LO on a completed nibble write and LO to HI on the second nibble, and it is forced back to HI when chip select goes inactive. The read-phase machine has states RD_GIVE_LO and RD_GIVE_HI. It moves on each completed nibble read and is forced back to RD_GIVE_LO when chip select goes inactive. The serial receiver has two states. It moves from SER_IDLE to SER_SHIFT when chip select becomes active and back to SER_IDLE when chip select is released, and SER_IDLE clears its bit counter.

Top module: `host_port_frontend`

## Requirements
- R1: A byte received with `dc_sel` high is delivered with `out_is_data` = 1 (display data). A byte received with `dc_sel` low is delivered with `out_is_data` = 0 (command).
- R2: 6800 mode (`cfg_i80`=0, `cfg_serial`=0): with `cs_n` low and `rw_wrn` low, one pulse of `en_rdn` high delivers the `host_d_i` byte once, when the enable falls.
- R3: 6800 mode: with `cs_n` low, `rw_wrn` high and `en_rdn` high, `host_d_oe` is high and `host_d_o` carries `rd_byte`. A read delivers no byte on `out_valid`.
- R4: 8080 mode (`cfg_i80`=1): with `cs_n` low, one low pulse on `rw_wrn` (write strobe) delivers the `host_d_i` byte once, when the strobe rises.
- R5: 8080 mode: with `cs_n` low and `en_rdn` (read strobe) low, `host_d_oe` is high and `host_d_o` carries `rd_byte`.
- R6: Nibble mode (`cfg_nibble`=1): each write strobe supplies four bits on `host_d_i[7:4]`. The first strobe after reset or after a chip-select release gives the high half, the second gives the low half, and the assembled byte is delivered once after the second strobe.
- R7: Nibble mode reads: the first read returns `rd_byte[3:0]` on `host_d_o[7:4]`, the next returns `rd_byte[7:4]`, and `host_d_o[3:0]` is 0.
- R8: Serial mode (`cfg_serial`=1): `host_d_i[7]` is data and `host_d_i[6]` is the clock. Bits are taken on clock rises, MSB first. The byte is delivered after the eighth rise, tagged with the `dc_sel` level at that rise.
- R9: In serial mode the `rw_wrn` and `en_rdn` pins are ignored: they deliver no byte and never raise `host_d_oe`.
- R10: A high `cs_n` aborts a half-received nibble pair or serial byte. Strobes while `cs_n` is high deliver nothing.
- R11: `host_d_oe` is low after reset and whenever no read is active.
- R12: `out_valid` is low after reset and is a single-cycle pulse, exactly one per completed transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_serial | input | 1 | Static: 1 selects the serial link |
| cfg_i80 | input | 1 | Static: 1 selects 8080 strobes, 0 selects 6800 strobes |
| cfg_nibble | input | 1 | Static: 1 selects 4-bit parallel transfers |
| cs_n | input | 1 | Chip select, active low |
| dc_sel | input | 1 | 1 = display data, 0 = command |
| rw_wrn | input | 1 | 6800 read/write level, or 8080 active-low write strobe |
| en_rdn | input | 1 | 6800 enable, or 8080 active-low read strobe |
| host_d_i | input | 8 | Bus value seen at the pad |
| host_d_o | output | 8 | Read value for the pad |
| host_d_oe | output | 1 | Pad drive enable; low means high impedance |
| rd_byte | input | 8 | Byte the controller returns on reads |
| out_byte | output | 8 | Received byte |
| out_is_data | output | 1 | Tag of `out_byte` |
| out_valid | output | 1 | One-cycle strobe for `out_byte` |

## Verification
The bench drives whole nibble pairs and serial bytes and then cuts them off halfway with a chip-select release. A design that kept the stale half or bit count would deliver a shifted byte such as 0xE3 instead of 0x3C. Consecutive nibble reads are checked for low-then-high order, which catches a swapped read phase. On the serial link the data/command level is changed just before the last bit, which separates latching at the eighth bit from latching at the first. A scoreboard flags any extra `out_valid` pulse. That catches level-sensitive strobe detection, reads that deliver bytes, and strobes that leak through in serial mode or while chip select is high.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
    localparam int BYTE_W = 8;
    localparam int NIB_W  = BYTE_W / 2;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef enum logic {WR_EXPECT_HI, WR_EXPECT_LO} wr_phase_e;
    typedef enum logic {RD_GIVE_LO, RD_GIVE_HI}     rd_phase_e;
    typedef enum logic {SER_IDLE, SER_SHIFT}        ser_state_e;
endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      stg[s] <= RST_VAL;
                else if (s == 0) stg[s] <= d;
                else             stg[s] <= stg[(s == 0) ? 0 : s - 1];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/hbi_par_rx.sv
module hbi_par_rx
    import hbi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              cfg_i80,
    input  logic              cfg_nibble,
    input  logic              cs_act,
    input  logic              dc,
    input  logic              pin_a,
    input  logic              pin_b,
    input  logic [BYTE_W-1:0] d,
    output logic              vld,
    output logic [BYTE_W-1:0] byte_o,
    output logic              is_data,
    output logic              rd_on,
    output logic              rd_hi
);
    wr_phase_e         wst, wst_nxt;
    rd_phase_e         rst, rst_nxt;
    logic              wr_on, wr_q, rd_q, wr_done, rd_done, live;
    logic [NIB_W-1:0]  hi_nib;

    assign live    = en && cs_act;
    assign wr_on   = live && (cfg_i80 ? !pin_a : (!pin_a && pin_b));
    assign rd_on   = live && (cfg_i80 ? !pin_b : (pin_a && pin_b));
    assign wr_done = wr_q && !wr_on && live;
    assign rd_done = rd_q && !rd_on && live;
    assign rd_hi   = (rst == RD_GIVE_HI);

    always_comb begin
        wst_nxt = wst;
        rst_nxt = rst;
        if (!live) begin
            wst_nxt = WR_EXPECT_HI;
            rst_nxt = RD_GIVE_LO;
        end else begin
            unique case (wst)
                WR_EXPECT_HI: if (wr_done && cfg_nibble) wst_nxt = WR_EXPECT_LO;
                WR_EXPECT_LO: if (wr_done) wst_nxt = WR_EXPECT_HI;
            endcase
            unique case (rst)
                RD_GIVE_LO: if (rd_done && cfg_nibble) rst_nxt = RD_GIVE_HI;
                RD_GIVE_HI: if (rd_done) rst_nxt = RD_GIVE_LO;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wst <= WR_EXPECT_HI;
            rst <= RD_GIVE_LO;
        end else begin
            wst <= wst_nxt;
            rst <= rst_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            rd_q    <= 1'b0;
            vld     <= 1'b0;
            byte_o  <= '0;
            is_data <= 1'b0;
            hi_nib  <= '0;
        end else begin
            wr_q <= wr_on;
            rd_q <= rd_on;
            vld  <= 1'b0;
            if (wr_done) begin
                if (!cfg_nibble) begin
                    vld     <= 1'b1;
                    byte_o  <= d;
                    is_data <= dc;
                end else if (wst == WR_EXPECT_HI) begin
                    hi_nib <= d[BYTE_W-1 -: NIB_W];
                end else begin
                    vld     <= 1'b1;
                    byte_o  <= {hi_nib, d[BYTE_W-1 -: NIB_W]};
                    is_data <= dc;
                end
            end
        end
    end

    // R10
    par_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (wst == WR_EXPECT_HI && rst == RD_GIVE_LO));
    // R6
    par_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && cfg_nibble && $past(cfg_nibble)) |-> $past(wst == WR_EXPECT_LO));
endmodule

// File: rtl/hbi_ser_rx.sv
module hbi_ser_rx
    import hbi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              cs_act,
    input  logic              dc,
    input  logic              sck,
    input  logic              sda,
    output logic              vld,
    output logic [BYTE_W-1:0] byte_o,
    output logic              is_data
);
    ser_state_e        st, st_nxt;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-2:0] sh;
    logic              sck_q, rise;

    assign rise = sck && !sck_q && (st == SER_SHIFT) && (st_nxt == SER_SHIFT);

    always_comb begin
        st_nxt = st;
        unique case (st)
            SER_IDLE:  if (en && cs_act)    st_nxt = SER_SHIFT;
            SER_SHIFT: if (!(en && cs_act)) st_nxt = SER_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= SER_IDLE;
        else        st <= st_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            sh      <= '0;
            sck_q   <= 1'b0;
            vld     <= 1'b0;
            byte_o  <= '0;
            is_data <= 1'b0;
        end else begin
            sck_q <= sck;
            vld   <= 1'b0;
            if (st_nxt == SER_IDLE) begin
                cnt <= '0;
            end else if (rise) begin
                sh  <= {sh[BYTE_W-3:0], sda};
                cnt <= cnt + 1'b1;
                if (cnt == CNT_W'(BYTE_W-1)) begin
                    vld     <= 1'b1;
                    byte_o  <= {sh, sda};
                    is_data <= dc;
                    cnt     <= '0;
                end
            end
        end
    end

    // R10
    ser_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (cnt == '0));
    // R8
    ser_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> (cnt == '0 && $past(cnt) == CNT_W'(BYTE_W-1)));
endmodule

// File: rtl/host_port_frontend.sv
module host_port_frontend
    import hbi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_serial,
    input  logic              cfg_i80,
    input  logic              cfg_nibble,
    input  logic              cs_n,
    input  logic              dc_sel,
    input  logic              rw_wrn,
    input  logic              en_rdn,
    input  logic [BYTE_W-1:0] host_d_i,
    output logic [BYTE_W-1:0] host_d_o,
    output logic              host_d_oe,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_is_data,
    output logic              out_valid
);
    localparam int SW = BYTE_W + 4;
    localparam logic [SW-1:0] SYNC_RST = {4'b1010, {BYTE_W{1'b0}}};

    logic [SW-1:0]     raw, syn;
    logic              s_cs_n, s_dc, s_a, s_b;
    logic [BYTE_W-1:0] s_d;
    logic              p_vld, p_dat, p_rd_on, p_rd_hi;
    logic              q_vld, q_dat;
    logic [BYTE_W-1:0] p_byte, q_byte;

    assign raw = {cs_n, dc_sel, rw_wrn, en_rdn, host_d_i};

    hbi_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
    );

    assign {s_cs_n, s_dc, s_a, s_b, s_d} = syn;

    hbi_par_rx u_par (
        .clk(clk), .rst_n(rst_n), .en(!cfg_serial), .cfg_i80(cfg_i80),
        .cfg_nibble(cfg_nibble), .cs_act(!s_cs_n), .dc(s_dc),
        .pin_a(s_a), .pin_b(s_b), .d(s_d),
        .vld(p_vld), .byte_o(p_byte), .is_data(p_dat),
        .rd_on(p_rd_on), .rd_hi(p_rd_hi)
    );

    hbi_ser_rx u_ser (
        .clk(clk), .rst_n(rst_n), .en(cfg_serial), .cs_act(!s_cs_n),
        .dc(s_dc), .sck(s_d[BYTE_W-2]), .sda(s_d[BYTE_W-1]),
        .vld(q_vld), .byte_o(q_byte), .is_data(q_dat)
    );

    assign out_valid   = p_vld | q_vld;
    assign out_byte    = cfg_serial ? q_byte : p_byte;
    assign out_is_data = cfg_serial ? q_dat  : p_dat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            host_d_oe <= 1'b0;
            host_d_o  <= '0;
        end else begin
            host_d_oe <= p_rd_on;
            if (!cfg_nibble)  host_d_o <= rd_byte;
            else if (p_rd_hi) host_d_o <= {rd_byte[BYTE_W-1 -: NIB_W], {NIB_W{1'b0}}};
            else              host_d_o <= {rd_byte[NIB_W-1:0], {NIB_W{1'b0}}};
        end
    end

    // R12
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
    // R9
    serial_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_serial) |-> !host_d_oe);
    // R3
    read_no_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_d_oe |-> !out_valid);
    // R11
    idle_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n, SYNC_STAGES + 1) && $past(cs_n, SYNC_STAGES) |-> !host_d_oe);
endmodule

// File: tb/tb_host_port_frontend.sv
module tb_host_port_frontend;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_serial = 1'b0, cfg_i80 = 1'b0, cfg_nibble = 1'b0;
    logic       cs_n = 1'b1, dc_sel = 1'b0, rw_wrn = 1'b0, en_rdn = 1'b0;
    logic [7:0] host_d_i = 8'h00, rd_byte = 8'h00;
    logic [7:0] host_d_o, out_byte;
    logic       host_d_oe, out_is_data, out_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [8:0] exp_q [$];
    string      req_q [$];

    always #(CLK_P/2) clk = ~clk;

    host_port_frontend dut (
        .clk(clk), .rst_n(rst_n), .cfg_serial(cfg_serial), .cfg_i80(cfg_i80),
        .cfg_nibble(cfg_nibble), .cs_n(cs_n), .dc_sel(dc_sel), .rw_wrn(rw_wrn),
        .en_rdn(en_rdn), .host_d_i(host_d_i), .host_d_o(host_d_o),
        .host_d_oe(host_d_oe), .rd_byte(rd_byte), .out_byte(out_byte),
        .out_is_data(out_is_data), .out_valid(out_valid)
    );

    task automatic chk(input bit ok, input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_byte(input bit is_d, input logic [7:0] b, input string req);
        exp_q.push_back({is_d, b});
        req_q.push_back(req);
    endtask

    // monitor: pops one expectation per out_valid pulse
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R12 unexpected byte", {out_is_data, out_byte}, 9'h000);
            end else begin
                automatic logic [8:0] e = exp_q.pop_front();
                automatic string r = req_q.pop_front();
                chk({out_is_data, out_byte} == e, r, {out_is_data, out_byte}, e);
            end
        end
    end

    task automatic w68(input bit d, input logic [7:0] b);
        dc_sel = d; host_d_i = b; rw_wrn = 1'b0; idle(3);
        en_rdn = 1'b1; idle(4);
        en_rdn = 1'b0; idle(6);
    endtask

    task automatic r68(input logic [7:0] exp, input string req);
        rw_wrn = 1'b1; idle(2);
        en_rdn = 1'b1; idle(6);
        chk(host_d_oe && host_d_o == exp, req, {host_d_oe, host_d_o}, {1'b1, exp});
        en_rdn = 1'b0; idle(4);
        rw_wrn = 1'b0; idle(4);
        chk(!host_d_oe, "R11 float after read", {8'h0, host_d_oe}, 9'h000);
    endtask

    task automatic w80(input bit d, input logic [7:0] b);
        dc_sel = d; host_d_i = b; idle(3);
        rw_wrn = 1'b0; idle(4);
        rw_wrn = 1'b1; idle(6);
    endtask

    task automatic r80(input logic [7:0] exp, input string req);
        en_rdn = 1'b0; idle(6);
        chk(host_d_oe && host_d_o == exp, req, {host_d_oe, host_d_o}, {1'b1, exp});
        en_rdn = 1'b1; idle(6);
        chk(!host_d_oe, "R11 float after read", {8'h0, host_d_oe}, 9'h000);
    endtask

    // serial: host_d_i[7] data, host_d_i[6] clock; last_dc applied before eighth rise
    task automatic sbits(input logic [7:0] b, input int nbits, input bit dc_first, input bit dc_last);
        for (int i = 7; i > 7 - nbits; i--) begin
            dc_sel = (i == 0) ? dc_last : dc_first;
            host_d_i[7] = b[i]; host_d_i[6] = 1'b0; idle(3);
            host_d_i[6] = 1'b1; idle(3);
        end
        host_d_i[6] = 1'b0; idle(6);
    endtask

    initial begin
        idle(3);
        chk(!out_valid, "R12 reset valid", {8'h0, out_valid}, 9'h000);
        chk(!host_d_oe, "R11 reset oe", {8'h0, host_d_oe}, 9'h000);
        rst_n = 1'b1; idle(4);

        // 6800 byte mode
        cs_n = 1'b0; idle(4);
        expect_byte(1'b0, 8'h3C, "R1 R2 6800 command write"); w68(1'b0, 8'h3C);
        expect_byte(1'b1, 8'hA5, "R1 R2 6800 data write");    w68(1'b1, 8'hA5);
        rd_byte = 8'h96; r68(8'h96, "R3 6800 read");
        cs_n = 1'b1; idle(4);
        w68(1'b1, 8'h77);   // R10: deselected strobe must deliver nothing
        chk(exp_q.size() == 0, "R2 6800 writes all delivered", 9'(exp_q.size()), 9'h000);

        // 8080 byte mode
        rw_wrn = 1'b1; en_rdn = 1'b1; cfg_i80 = 1'b1; idle(6);
        cs_n = 1'b0; idle(4);
        expect_byte(1'b0, 8'h11, "R1 R4 8080 command write"); w80(1'b0, 8'h11);
        expect_byte(1'b1, 8'hFE, "R1 R4 8080 data write");    w80(1'b1, 8'hFE);
        rd_byte = 8'h2D; r80(8'h2D, "R5 8080 read");

        // 8080 nibble mode
        cs_n = 1'b1; cfg_nibble = 1'b1; idle(6);
        cs_n = 1'b0; idle(4);
        expect_byte(1'b1, 8'hB7, "R6 8080 nibble pair");
        w80(1'b1, 8'hB0); w80(1'b1, 8'h70);
        rd_byte = 8'h5A;
        r80(8'hA0, "R7 nibble read low first");
        r80(8'h50, "R7 nibble read high second");
        // abort of a half pair
        w80(1'b0, 8'hE0);
        cs_n = 1'b1; idle(6);
        cs_n = 1'b0; idle(4);
        expect_byte(1'b0, 8'h3C, "R10 nibble abort restarts high");
        w80(1'b0, 8'h30); w80(1'b0, 8'hC0);

        // 6800 nibble mode
        cs_n = 1'b1; rw_wrn = 1'b0; en_rdn = 1'b0; cfg_i80 = 1'b0; idle(6);
        cs_n = 1'b0; idle(4);
        expect_byte(1'b0, 8'h91, "R6 6800 nibble pair");
        w68(1'b0, 8'h90); w68(1'b0, 8'h10);
        rd_byte = 8'hC3;
        r68(8'h30, "R7 6800 nibble read low first");
        r68(8'hC0, "R7 6800 nibble read high second");

        // serial mode
        cs_n = 1'b1; cfg_nibble = 1'b0; cfg_serial = 1'b1; host_d_i = 8'h00; idle(6);
        cs_n = 1'b0; idle(4);
        expect_byte(1'b0, 8'hA7, "R8 serial command byte"); sbits(8'hA7, 8, 1'b0, 1'b0);
        expect_byte(1'b1, 8'h5E, "R1 R8 dc taken at eighth bit"); sbits(8'h5E, 8, 1'b0, 1'b1);
        sbits(8'hFF, 3, 1'b1, 1'b1);
        cs_n = 1'b1; idle(6);
        cs_n = 1'b0; idle(4);
        expect_byte(1'b1, 8'h81, "R10 serial abort"); sbits(8'h81, 8, 1'b1, 1'b1);
        // R9: parallel strobes ignored in serial mode
        rw_wrn = 1'b1; en_rdn = 1'b1; idle(6);
        chk(!host_d_oe, "R9 no drive in serial", {8'h0, host_d_oe}, 9'h000);
        rw_wrn = 1'b0; idle(4); en_rdn = 1'b0; idle(4); en_rdn = 1'b1; idle(4);
        en_rdn = 1'b0; idle(6);
        chk(!host_d_oe, "R9 no drive after strobes", {8'h0, host_d_oe}, 9'h000);

        idle(10);
        chk(exp_q.size() == 0, "R12 all bytes delivered", 9'(exp_q.size()), 9'h000);
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule